// File: doc/BRIEF.md
# MFM pulse-interval bit decoder

This block turns the raw read-data pulse train of a double-density floppy drive into decoded data bits. The active-low pulse input is synchronised, and the time between successive falling edges is measured by a counter that advances once every four clock cycles. Each measured interval is sorted against three programmable thresholds into one of four classes: too short, short, medium or long. The class is combined with the previously decoded data bit to produce one or two new bits. A long interval seen after a 0 is the missing-clock pattern, and the two bits it yields are flagged as sync bits.

Decoding runs only inside a read window. While the arm input is high, each index strobe toggles the window. The first falling edge after the window opens only starts the timing. Decoded bits leave one at a time with a one-cycle strobe. They are also collected in a data shift register and in a matching sync-mark shift register. A bit counter and a saturating bad-pulse counter run alongside. Byte framing and CRC checking belong to downstream logic.

Top module: `mfm_interval_decoder`

## Requirements
- R1: After reset the window is closed, `bit_valid`, `bit_data` and `bit_sync` are 0, and both counters and both shift registers are zero.
- R2: While `arm` is 1, each `index_strobe` cycle toggles `window_open` on the next clock. When `arm` is 0 the window is closed. Falling edges seen while the window is closed produce no bits and leave the counters unchanged.
- R3: The first falling edge after the window opens only restarts timing and emits nothing. For each later edge, the measured count equals floor((D-1)/4), where D is the number of clock cycles since the previous edge. The count saturates at 255 instead of wrapping, and the counter restarts from zero on every edge.
- R4: A count below `thr_bad` is too short: it emits no bit and raises `bad_count` by one, saturating at its maximum. Otherwise a count below `thr_sm` is short, a count below `thr_ml` is medium, and any other count is long.
- R5: A short interval emits one bit equal to the last data bit, with sync 0, and leaves the last bit unchanged.
- R6: A medium interval after a 0 emits a single 1, and the last bit becomes 1. A medium interval after a 1 emits 0 then 0, and the last bit becomes 0. Sync is 0 in both cases.
- R7: A long interval after a 1 emits 0 then 1 with sync 0, and the last bit stays 1. A long interval after a 0 emits 0 then 0, each with sync 1, and the last bit stays 0.
- R8: Each bit is presented for exactly one cycle with `bit_valid` high. The two bits of a pair appear on consecutive cycles, the earlier bit first. Each emitted bit enters bit 0 of `data_shift`, and its sync flag enters bit 0 of `sync_shift`.
- R9: `bit_count` rises by the number of bits each interval emits. `bit_count`, `bad_count`, both shift registers and the last data bit (set to 0) are cleared when the window opens, and they hold their values after it closes.
- R10: A falling edge detected in the same cycle as `index_strobe` is not decoded, whether that strobe opens the window or closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Enables window toggling; low forces the window closed |
| index_strobe | input | 1 | Synchronous one-cycle index pulse |
| rd_n | input | 1 | Asynchronous active-low read-data pulses |
| thr_bad | input | 8 | Counts below this are too short |
| thr_sm | input | 8 | Short/medium boundary |
| thr_ml | input | 8 | Medium/long boundary |
| window_open | output | 1 | Read window state |
| bit_valid | output | 1 | One-cycle strobe for each decoded bit |
| bit_data | output | 1 | Decoded data bit |
| bit_sync | output | 1 | Bit belongs to a missing-clock pattern |
| data_shift | output | 16 | Most recent decoded bits, newest in bit 0 |
| sync_shift | output | 16 | Sync marks aligned with `data_shift` |
| bit_count | output | 16 | Decoded bits in this window (wraps) |
| bad_count | output | 8 | Too-short intervals in this window (saturates) |

## Verification
Two events can land in the same clock cycle: a detected falling edge and an index strobe that opens or closes the window. The bench lines them up by dropping `rd_n` and raising `index_strobe` two cycles later, which matches the synchroniser delay. For a closing strobe it checks that no bit appears and that `bit_count` does not move. For an opening strobe it checks that the following pulse only primes the timer and is not decoded. The bench also uses the shortest legal pulse spacing, which makes the second bit of a pair leave in the same cycle that the next edge is captured.

// File: rtl/mfm_dec_pkg.sv
package mfm_dec_pkg;

  typedef enum logic [1:0] {
    CLS_BAD   = 2'd0,
    CLS_SHORT = 2'd1,
    CLS_MED   = 2'd2,
    CLS_LONG  = 2'd3
  } ivl_class_e;

  typedef struct packed {
    logic [1:0] nbits;     // 0, 1 or 2 bits emitted
    logic       b0;        // earlier bit
    logic       b1;        // later bit (pairs only)
    logic       s0;
    logic       s1;
    logic       next_last;
  } decode_t;

  // Sort a measured count into a class using strict less-than boundaries.
  function automatic ivl_class_e classify(input logic [7:0] cnt,
                                          input logic [7:0] t_bad,
                                          input logic [7:0] t_sm,
                                          input logic [7:0] t_ml);
    if (cnt < t_bad)     return CLS_BAD;
    else if (cnt < t_sm) return CLS_SHORT;
    else if (cnt < t_ml) return CLS_MED;
    else                 return CLS_LONG;
  endfunction

  // Turn a class and the previous data bit into emitted bits.
  function automatic decode_t mfm_decode(input ivl_class_e c, input logic last);
    decode_t d;
    d = '0;
    d.next_last = last;
    case (c)
      CLS_SHORT: begin
        d.nbits = 2'd1;
        d.b0    = last;
      end
      CLS_MED: begin
        if (!last) begin
          d.nbits     = 2'd1;
          d.b0        = 1'b1;
          d.next_last = 1'b1;
        end else begin
          d.nbits     = 2'd2;
          d.next_last = 1'b0;
        end
      end
      CLS_LONG: begin
        d.nbits = 2'd2;
        if (last) begin
          d.b1 = 1'b1;
        end else begin
          d.s0 = 1'b1;
          d.s1 = 1'b1;
        end
      end
      default: d.nbits = 2'd0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mfm_edge_sync.sv
module mfm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rd_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 & ~s2;

  a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/mfm_interval_timer.sv
module mfm_interval_timer #(
  parameter int PRESCALE = 4,
  parameter int CW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fall,
  output logic          ev_valid,
  output logic [CW-1:0] ev_count
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [CW-1:0] CNT_MAX  = '1;

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic          primed;
  logic          tick;

  assign tick = (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      cnt    <= '0;
      primed <= 1'b0;
    end else if (!run) begin
      pre    <= '0;
      cnt    <= '0;
      primed <= 1'b0;
    end else if (fall) begin
      pre    <= '0;
      cnt    <= '0;
      primed <= 1'b1;
    end else begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick && cnt != CNT_MAX) cnt <= cnt + CW'(1);
    end
  end

  assign ev_valid = run & fall & primed;
  assign ev_count = cnt;

  a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fall && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
  a_r3_prime_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> !ev_valid);
endmodule

// File: rtl/mfm_bit_emitter.sv
module mfm_bit_emitter
  import mfm_dec_pkg::*;
#(
  parameter int BC_W  = 16,
  parameter int BAD_W = 8,
  parameter int SR_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ev_valid,
  input  logic [7:0]       ev_count,
  input  logic [7:0]       thr_bad,
  input  logic [7:0]       thr_sm,
  input  logic [7:0]       thr_ml,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             bit_sync,
  output logic [SR_W-1:0]  data_shift,
  output logic [SR_W-1:0]  sync_shift,
  output logic [BC_W-1:0]  bit_count,
  output logic [BAD_W-1:0] bad_count
);
  localparam logic [BAD_W-1:0] BAD_MAX = '1;

  ivl_class_e cls;
  decode_t    dec;
  logic       last_bit;
  logic       pend_valid, pend_d, pend_s;
  logic       emit, emit_d, emit_s;

  assign cls = classify(ev_count, thr_bad, thr_sm, thr_ml);
  assign dec = mfm_decode(cls, last_bit);

  // One bit leaves per cycle: a fresh decode first, else the pending half.
  always_comb begin
    emit   = 1'b0;
    emit_d = 1'b0;
    emit_s = 1'b0;
    if (ev_valid && cls != CLS_BAD) begin
      emit   = 1'b1;
      emit_d = dec.b0;
      emit_s = dec.s0;
    end else if (pend_valid) begin
      emit   = 1'b1;
      emit_d = pend_d;
      emit_s = pend_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_bit   <= 1'b0;
      pend_valid <= 1'b0;
      pend_d     <= 1'b0;
      pend_s     <= 1'b0;
      bit_valid  <= 1'b0;
      bit_data   <= 1'b0;
      bit_sync   <= 1'b0;
      data_shift <= '0;
      sync_shift <= '0;
      bit_count  <= '0;
      bad_count  <= '0;
    end else if (clear) begin
      last_bit   <= 1'b0;
      pend_valid <= 1'b0;
      pend_d     <= 1'b0;
      pend_s     <= 1'b0;
      bit_valid  <= 1'b0;
      bit_data   <= 1'b0;
      bit_sync   <= 1'b0;
      data_shift <= '0;
      sync_shift <= '0;
      bit_count  <= '0;
      bad_count  <= '0;
    end else begin
      bit_valid <= emit;
      bit_data  <= emit_d;
      bit_sync  <= emit_s;
      if (emit) begin
        data_shift <= {data_shift[SR_W-2:0], emit_d};
        sync_shift <= {sync_shift[SR_W-2:0], emit_s};
      end
      if (ev_valid) begin
        if (cls == CLS_BAD) begin
          if (bad_count != BAD_MAX) bad_count <= bad_count + BAD_W'(1);
          pend_valid <= 1'b0;
        end else begin
          pend_valid <= (dec.nbits == 2'd2);
          pend_d     <= dec.b1;
          pend_s     <= dec.s1;
          last_bit   <= dec.next_last;
          bit_count  <= bit_count + BC_W'(dec.nbits);
        end
      end else begin
        pend_valid <= 1'b0;
      end
    end
  end

  a_r4_bad_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && cls == CLS_BAD && !pend_valid) |=> !bit_valid);
  a_r7_sync_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_sync) |=> bit_sync);
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> !ev_valid);
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !clear) |=> $stable(bit_count));
endmodule

// File: rtl/mfm_interval_decoder.sv
module mfm_interval_decoder
  import mfm_dec_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int BC_W     = 16,
  parameter int BAD_W    = 8,
  parameter int SR_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             index_strobe,
  input  logic             rd_n,
  input  logic [7:0]       thr_bad,
  input  logic [7:0]       thr_sm,
  input  logic [7:0]       thr_ml,
  output logic             window_open,
  output logic             bit_valid,
  output logic             bit_data,
  output logic             bit_sync,
  output logic [SR_W-1:0]  data_shift,
  output logic [SR_W-1:0]  sync_shift,
  output logic [BC_W-1:0]  bit_count,
  output logic [BAD_W-1:0] bad_count
);
  logic       win;
  logic       open_pulse;
  logic       run;
  logic       fall;
  logic       ev_valid;
  logic [7:0] ev_count;

  assign open_pulse = arm & index_strobe & ~win;
  assign run        = win & arm & ~index_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            win <= 1'b0;
    else if (!arm)         win <= 1'b0;
    else if (index_strobe) win <= ~win;
  end

  assign window_open = win;

  mfm_edge_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_n  (rd_n),
    .fall  (fall)
  );

  mfm_interval_timer #(.PRESCALE(PRESCALE), .CW(8)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .fall     (fall),
    .ev_valid (ev_valid),
    .ev_count (ev_count)
  );

  mfm_bit_emitter #(.BC_W(BC_W), .BAD_W(BAD_W), .SR_W(SR_W)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (open_pulse),
    .ev_valid   (ev_valid),
    .ev_count   (ev_count),
    .thr_bad    (thr_bad),
    .thr_sm     (thr_sm),
    .thr_ml     (thr_ml),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_sync   (bit_sync),
    .data_shift (data_shift),
    .sync_shift (sync_shift),
    .bit_count  (bit_count),
    .bad_count  (bad_count)
  );

  a_r2_events_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> window_open);
  a_r10_index_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (index_strobe && fall) |-> !ev_valid);
  a_r2_arm_low_closes: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !window_open);
endmodule

// File: tb/mfm_interval_decoder_test.sv
`timescale 1ns/1ps
module mfm_interval_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        index_strobe = 1'b0;
  logic        rd_n = 1'b1;
  logic [7:0]  thr_bad = 8'd20, thr_sm = 8'd40, thr_ml = 8'd60;
  logic        window_open, bit_valid, bit_data, bit_sync;
  logic [15:0] data_shift, sync_shift, bit_count;
  logic [7:0]  bad_count;

  always #2.5 clk = ~clk;

  mfm_interval_decoder uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .index_strobe(index_strobe), .rd_n(rd_n),
    .thr_bad(thr_bad), .thr_sm(thr_sm), .thr_ml(thr_ml),
    .window_open(window_open), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_sync(bit_sync), .data_shift(data_shift), .sync_shift(sync_shift),
    .bit_count(bit_count), .bad_count(bad_count)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit exp_dq[$];
  bit exp_sq[$];
  bit exp_last = 0;
  int exp_bits = 0, exp_bad = 0;
  logic [15:0] exp_dsh = '0, exp_ssh = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ticks_for(input int gap);
    int t;
    t = 0;
    for (int c = 4; c < gap; c += 4) t++;   // one tick per full prescale period
    if (t > 255) t = 255;
    return t;
  endfunction

  task automatic push_bit(input bit d, input bit s);
    exp_dq.push_back(d);
    exp_sq.push_back(s);
    exp_bits++;
    exp_dsh = {exp_dsh[14:0], d};
    exp_ssh = {exp_ssh[14:0], s};
  endtask

  task automatic model(input int gap);
    int t;
    t = ticks_for(gap);
    if (t < thr_bad) begin
      if (exp_bad < 255) exp_bad++;
    end else if (t < thr_sm) begin
      push_bit(exp_last, 0);
    end else if (t < thr_ml) begin
      if (exp_last) begin push_bit(0, 0); push_bit(0, 0); exp_last = 0; end
      else begin push_bit(1, 0); exp_last = 1; end
    end else begin
      if (exp_last) begin push_bit(0, 0); push_bit(1, 0); end
      else begin push_bit(0, 1); push_bit(0, 1); end
    end
  endtask

  // Falling edge `gap` cycles after the previous one.
  task automatic pulse(input int gap, input bit decoded);
    repeat (gap - 2) @(negedge clk);
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk) rd_n = 1'b1;
    if (decoded) model(gap);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_index();
    @(negedge clk) index_strobe = 1'b1;
    @(negedge clk) index_strobe = 1'b0;
  endtask

  task automatic reset_model();
    exp_last = 0; exp_bits = 0; exp_bad = 0; exp_dsh = '0; exp_ssh = '0;
  endtask

  // Edge detected in the same cycle as the index strobe.
  task automatic collide();
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk) rd_n = 1'b1;
    @(negedge clk) index_strobe = 1'b1;
    @(negedge clk) index_strobe = 1'b0;
  endtask

  task automatic check_totals(input string tag);
    check(exp_dq.size() == 0, "R8", {tag, " pending expected bits"}, exp_dq.size(), 0);
    check(bit_count == 16'(exp_bits), "R9", {tag, " bit_count"}, bit_count, 16'(exp_bits));
    check(bad_count == 8'(exp_bad), "R4", {tag, " bad_count"}, bad_count, exp_bad);
    check(data_shift == exp_dsh, "R8", {tag, " data_shift"}, data_shift, exp_dsh);
    check(sync_shift == exp_ssh, "R7", {tag, " sync_shift"}, sync_shift, exp_ssh);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Scoreboard: every strobed bit must match the model, in order.
  bit prev_valid = 0;
  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      if (exp_dq.size() == 0) begin
        check(0, "R8", "unexpected bit", bit_data, -1);
      end else begin
        bit d, s;
        d = exp_dq.pop_front();
        s = exp_sq.pop_front();
        check(bit_data == d, "R8", "bit_data", bit_data, d);
        check(bit_sync == s, "R7", "bit_sync", bit_sync, s);
      end
    end
    prev_valid = bit_valid;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    settle(4);
    // R1 reset state
    check(window_open == 0, "R1", "window_open", window_open, 0);
    check(bit_valid == 0 && bit_sync == 0 && bit_data == 0, "R1", "bit outputs", bit_valid, 0);
    check(bit_count == 0 && bad_count == 0, "R1", "counters", bit_count, 0);
    check(data_shift == 0 && sync_shift == 0, "R1", "shifts", data_shift, 0);
    rst_n = 1'b1;
    settle(3);

    // R2: edges outside the window do nothing
    arm = 1'b1;
    pulse(2, 0); pulse(200, 0); pulse(130, 0);
    settle(8);
    check(bit_count == 0, "R2", "bit_count outside window", bit_count, 0);
    check(exp_dq.size() == 0, "R2", "no bits outside window", exp_dq.size(), 0);

    // Open window, prime, directed sequence (R3..R7)
    do_index(); reset_model();
    check(window_open == 1, "R2", "window opens", window_open, 1);
    settle(5);
    pulse(2, 0);                // R3 prime only
    pulse(4*30+1, 1);           // R5 short after 0 -> 0
    pulse(4*50+1, 1);           // R6 medium after 0 -> 1
    pulse(4*30+1, 1);           // R5 short after 1 -> 1
    pulse(4*50+1, 1);           // R6 medium after 1 -> 00
    pulse(4*70+1, 1);           // R7 long after 0 -> 00 sync
    pulse(4*70+1, 1);           // R7 again, back-to-back sync pairs
    pulse(4*50+1, 1);           // R6 -> 1
    pulse(4*70+1, 1);           // R7 long after 1 -> 01
    pulse(4*20, 1);             // R4 count 19 too short
    pulse(4*20+1, 1);           // R4 count 20 short
    pulse(4*40, 1);             // R4 count 39 short
    pulse(4*40+1, 1);           // R4 count 40 medium
    pulse(4*300+1, 1);          // R3 saturates at 255 -> long
    pulse(2, 1);                // R3 minimum spacing, too short
    pulse(4*70+1, 1);
    pulse(2, 1);
    settle(8);
    check_totals("directed");

    // Random intervals, minimum spacing mixed in (R3..R8)
    for (int i = 0; i < 300; i++) begin
      int g;
      g = ($urandom_range(0, 7) == 0) ? 2 : 2 + int'($urandom_range(0, 330));
      pulse(g, 1);
    end
    settle(8);
    check_totals("random A");

    // Close, then pulses outside must not move the held counters (R9, R2)
    do_index();
    check(window_open == 0, "R2", "window closes", window_open, 0);
    pulse(200, 0); pulse(4*70+1, 0);
    settle(8);
    check_totals("held after close");

    // Second random round with other thresholds (R4)
    thr_bad = 8'd10; thr_sm = 8'd70; thr_ml = 8'd100;
    do_index(); reset_model();
    settle(5);
    pulse(2, 0);
    for (int i = 0; i < 200; i++) pulse(2 + int'($urandom_range(0, 500)), 1);
    settle(8);
    check_totals("random B");
    thr_bad = 8'd20; thr_sm = 8'd40; thr_ml = 8'd60;

    // R10 closing collision: edge in closing cycle is dropped
    settle(4);
    pulse(4*30+1, 1);
    settle(8);
    collide();
    settle(8);
    check(window_open == 0, "R10", "closed by colliding strobe", window_open, 0);
    check_totals("close collision R10");

    // R10 opening collision: the next edge only primes
    collide(); reset_model();
    check(window_open == 1, "R10", "opened by colliding strobe", window_open, 1);
    pulse(4*50+1, 0);           // would be decoded if the collision edge had primed
    pulse(4*30+1, 1);
    settle(8);
    check_totals("open collision R10");

    // R4 bad counter saturation
    do_index(); settle(4);
    do_index(); reset_model();
    settle(4);
    pulse(2, 0);
    for (int i = 0; i < 300; i++) pulse(2, 1);
    settle(8);
    check(bad_count == 8'd255, "R4", "bad_count saturates", bad_count, 255);
    check_totals("bad saturation");

    // R2 arm low forces the window closed
    @(negedge clk) arm = 1'b0;
    @(negedge clk);
    check(window_open == 0, "R2", "arm low closes", window_open, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule